// File: doc/BRIEF.md
# Power Path Degradation Policy Controller

This controller decides, cycle by cycle, whether one protected power path may conduct. It moves between three policy states. In Allow the path is on at full current. In Limit the path stays on at a reduced current-limit step. In Deny the path is switched off. Fault strobes first walk the current limit down a ladder of steps. A fault on the last step, or over-temperature at any moment, cuts the power.

Once power is cut, the controller brings the path back through a retry. Each retry waits a backoff delay that grows with the retry count. When the retry budget is used up, the Deny state latches. Only a clear command issued after a cool-down period releases it. A fault-free period while in Limit raises the limit one step at a time until the path is back in Allow. Every change of policy state, every change of limit step and every accepted clear produces a one-cycle log strobe. The strobe names the cause and the new state. The timers count a 1 ms tick input rather than clock cycles.

Top module: `pwr_policy_fsm`

## Requirements
- R1: After reset the policy state is Deny (code 2), enable is low, the limit step is 0, the retry index is 0 and no log strobe is raised.
- R2: The block enters Allow (code 0) only from Deny, and only when admission is high, over-temperature is low, the block is not latched and no backoff is pending. Enable is high exactly in Allow and in Limit (code 1).
- R3: A fault strobe in Allow moves the block to Limit with limit step 1 in the next cycle.
- R4: A fault in Limit below the last step (LIM_STEPS) raises the step by one. A fault at the last step moves the block to Deny.
- R5: Over-temperature in Allow or Limit forces Deny in the next cycle, even when a fault arrives in the same cycle. While over-temperature is high, the block never leaves Deny.
- R6: A falling edge on admission in Allow or Limit counts as one fault event, with log source PG. A level that stays low raises no further events.
- R7: In Limit, RECOVER_MS consecutive ticks without a fault event lower the step by one. Reaching step 0 returns the block to Allow. Ticks in Allow change nothing.
- R8: Entering Deny with retry index k below RETRY_MAX raises the index to k+1 and starts a backoff of BACKOFF0_MS, BACKOFF1_MS or BACKOFF2_MS ticks for k = 0, 1 or 2 and above. Once that many ticks have passed, the block re-enters Allow in the next cycle if admission allows it.
- R9: Entering Deny with the retry index already at RETRY_MAX latches the block. The index stays as it is, and no number of ticks releases the latch.
- R10: A clear command takes effect only in Deny, and only once COOL_MS ticks have passed since Deny was entered. It unlatches the block, zeroes the retry index and drops any backoff still pending. A clear given earlier in Deny, or in Allow or Limit, has no effect.
- R11: Each policy-state change, limit-step change and accepted clear raises log_vld for one cycle, together with the new state on log_dec and the cause on log_src (1 PG, 2 FAULT, 3 THERM, 4 recovery timer, 5 clear command, 0 when idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| admit | input | 1 | Voted, debounced and guarded power-good admission |
| fault | input | 1 | Fault strobe from the protection device |
| over_temp | input | 1 | Over-temperature level |
| clr_cmd | input | 1 | Clear command for the Deny latch |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pwr_en | output | 1 | Power path enable |
| lim_lvl | output | LW | Current-limit step, 0 = full current |
| pol_state | output | 2 | Policy state: 0 Allow, 1 Limit, 2 Deny |
| retry_idx | output | RW | Retries used since the last clear |
| log_vld | output | 1 | One-cycle log event strobe |
| log_src | output | 3 | Cause of the logged event |
| log_dec | output | 2 | Policy state after the logged event |

## Verification
Every piece of internal state in this block shows at the ports within one cycle of the event that uses it. A wrong step count shows as a wrong lim_lvl, or as Deny arriving one fault too early or too late. A wrong retry count shows as a wrong retry_idx and as the wrong backoff length. The bench counts ticks between Deny and the return to Allow, so a backoff or cool-down counter that is off by one tick moves the exit or the accepted clear by exactly one tick. A recovery counter that is not reset by a fault event shows up as an early step-up after an admission drop.

// File: rtl/pwr_policy_fsm.sv
`timescale 1ns/1ps
module pwr_policy_fsm #(
  parameter int LIM_STEPS   = 2,
  parameter int RETRY_MAX   = 3,
  parameter int BACKOFF0_MS = 20,
  parameter int BACKOFF1_MS = 80,
  parameter int BACKOFF2_MS = 200,
  parameter int COOL_MS     = 200,
  parameter int RECOVER_MS  = 500,
  localparam int LW = (LIM_STEPS < 1) ? 1 : $clog2(LIM_STEPS + 1),
  localparam int RW = $clog2(RETRY_MAX + 1),
  localparam int M1 = (BACKOFF0_MS > BACKOFF1_MS) ? BACKOFF0_MS : BACKOFF1_MS,
  localparam int M2 = (M1 > BACKOFF2_MS) ? M1 : BACKOFF2_MS,
  localparam int M3 = (M2 > COOL_MS) ? M2 : COOL_MS,
  localparam int TMAX = (M3 > RECOVER_MS) ? M3 : RECOVER_MS,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          admit,
  input  logic          fault,
  input  logic          over_temp,
  input  logic          clr_cmd,
  input  logic          ms_tick,
  output logic          pwr_en,
  output logic [LW-1:0] lim_lvl,
  output logic [1:0]    pol_state,
  output logic [RW-1:0] retry_idx,
  output logic          log_vld,
  output logic [2:0]    log_src,
  output logic [1:0]    log_dec
);

  localparam logic [1:0] ST_ALLOW = 2'd0;
  localparam logic [1:0] ST_LIMIT = 2'd1;
  localparam logic [1:0] ST_DENY  = 2'd2;

  localparam logic [2:0] SRC_NONE  = 3'd0;
  localparam logic [2:0] SRC_PG    = 3'd1;
  localparam logic [2:0] SRC_FAULT = 3'd2;
  localparam logic [2:0] SRC_THERM = 3'd3;
  localparam logic [2:0] SRC_TIMER = 3'd4;
  localparam logic [2:0] SRC_CMD   = 3'd5;

  logic [1:0]    st, st_n;
  logic [LW-1:0] lvl, lvl_n;
  logic [RW-1:0] rtr, rtr_n;
  logic          lat, lat_n;
  logic [TW-1:0] bo, bo_n, cd, cd_n, rq, rq_n;
  logic          admit_q;
  logic          lg_n;
  logic [2:0]    src_n, deny_src;
  logic          deny_req;

  logic       pg_drop, flt_ev;
  logic [2:0] flt_src;
  assign pg_drop = admit_q & ~admit;
  assign flt_ev  = fault | pg_drop;
  assign flt_src = fault ? SRC_FAULT : SRC_PG;

  function automatic logic [TW-1:0] backoff_of(input logic [RW-1:0] idx);
    if (idx == '0) return TW'(BACKOFF0_MS);
    if (idx == RW'(1)) return TW'(BACKOFF1_MS);
    return TW'(BACKOFF2_MS);
  endfunction

  always_comb begin
    st_n     = st;
    lvl_n    = lvl;
    rtr_n    = rtr;
    lat_n    = lat;
    rq_n     = rq;
    bo_n     = (ms_tick && bo != '0) ? bo - TW'(1) : bo;
    cd_n     = (ms_tick && cd != '0) ? cd - TW'(1) : cd;
    lg_n     = 1'b0;
    src_n    = SRC_NONE;
    deny_req = 1'b0;
    deny_src = SRC_NONE;

    case (st)
      ST_ALLOW, ST_LIMIT: begin
        if (over_temp) begin
          deny_req = 1'b1;
          deny_src = SRC_THERM;
        end else if (flt_ev) begin
          rq_n = '0;
          if (st == ST_ALLOW) begin
            st_n  = ST_LIMIT;
            lvl_n = LW'(1);
            lg_n  = 1'b1;
            src_n = flt_src;
          end else if (lvl < LW'(LIM_STEPS)) begin
            lvl_n = lvl + LW'(1);
            lg_n  = 1'b1;
            src_n = flt_src;
          end else begin
            deny_req = 1'b1;
            deny_src = flt_src;
          end
        end else if (st == ST_LIMIT && ms_tick) begin
          if (rq == TW'(RECOVER_MS - 1)) begin
            rq_n  = '0;
            lvl_n = lvl - LW'(1);
            lg_n  = 1'b1;
            src_n = SRC_TIMER;
            if (lvl == LW'(1)) st_n = ST_ALLOW;
          end else begin
            rq_n = rq + TW'(1);
          end
        end
      end
      default: begin
        if (clr_cmd && cd == '0) begin
          lat_n = 1'b0;
          rtr_n = '0;
          bo_n  = '0;
          lg_n  = 1'b1;
          src_n = SRC_CMD;
        end else if (!lat && bo == '0 && admit && !over_temp) begin
          st_n  = ST_ALLOW;
          lvl_n = '0;
          rq_n  = '0;
          lg_n  = 1'b1;
          src_n = SRC_PG;
        end
      end
    endcase

    if (deny_req) begin
      st_n  = ST_DENY;
      cd_n  = TW'(COOL_MS);
      rq_n  = '0;
      lg_n  = 1'b1;
      src_n = deny_src;
      if (rtr < RW'(RETRY_MAX)) begin
        bo_n  = backoff_of(rtr);
        rtr_n = rtr + RW'(1);
      end else begin
        lat_n = 1'b1;
        bo_n  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_DENY;
      lvl     <= '0;
      rtr     <= '0;
      lat     <= 1'b0;
      bo      <= '0;
      cd      <= '0;
      rq      <= '0;
      admit_q <= 1'b0;
      log_vld <= 1'b0;
      log_src <= SRC_NONE;
      log_dec <= ST_DENY;
    end else begin
      st      <= st_n;
      lvl     <= lvl_n;
      rtr     <= rtr_n;
      lat     <= lat_n;
      bo      <= bo_n;
      cd      <= cd_n;
      rq      <= rq_n;
      admit_q <= admit;
      log_vld <= lg_n;
      log_src <= src_n;
      log_dec <= st_n;
    end
  end

  assign pwr_en    = (st != ST_DENY);
  assign pol_state = st;
  assign lim_lvl   = lvl;
  assign retry_idx = rtr;

endmodule

// File: rtl/pwr_policy_fsm_chk.sv
`timescale 1ns/1ps
module pwr_policy_fsm_chk #(
  parameter int LIM_STEPS = 2,
  parameter int RETRY_MAX = 3,
  localparam int LW = (LIM_STEPS < 1) ? 1 : $clog2(LIM_STEPS + 1),
  localparam int RW = $clog2(RETRY_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          admit,
  input logic          fault,
  input logic          over_temp,
  input logic          clr_cmd,
  input logic          pwr_en,
  input logic [LW-1:0] lim_lvl,
  input logic [1:0]    pol_state,
  input logic [RW-1:0] retry_idx,
  input logic          log_vld,
  input logic [1:0]    log_dec
);

  a_r2_rise_needs_admit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> ($past(admit) && !$past(over_temp)));

  a_r3_first_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state == 2'd0 && fault && !over_temp) |=> (pol_state == 2'd1 && lim_lvl == LW'(1)));

  a_r4_last_step_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state == 2'd1 && lim_lvl == LW'(LIM_STEPS) && fault && !over_temp) |=> (pol_state == 2'd2));

  a_r5_therm_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state != 2'd2 && over_temp) |=> (pol_state == 2'd2 && !pwr_en));

  a_r5_therm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state == 2'd2 && over_temp) |=> (pol_state == 2'd2));

  a_r7_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state == 2'd1) |-> (lim_lvl != '0 && lim_lvl <= LW'(LIM_STEPS)));

  a_r8_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retry_idx <= RW'(RETRY_MAX));

  a_r10_clear_outside_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state != 2'd2 && clr_cmd && admit && !fault && !over_temp) |=> (retry_idx == $past(retry_idx)));

  a_r11_log_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_state != $past(pol_state)) |-> (log_vld && log_dec == pol_state));

endmodule

bind pwr_policy_fsm pwr_policy_fsm_chk #(.LIM_STEPS(LIM_STEPS), .RETRY_MAX(RETRY_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .admit(admit), .fault(fault), .over_temp(over_temp),
  .clr_cmd(clr_cmd), .pwr_en(pwr_en), .lim_lvl(lim_lvl), .pol_state(pol_state),
  .retry_idx(retry_idx), .log_vld(log_vld), .log_dec(log_dec)
);

// File: tb/sim_pwr_policy_fsm.sv
`timescale 1ns/1ps
module sim_pwr_policy_fsm;
  localparam int STEPS = 2;
  localparam int RMAX  = 2;
  localparam int BO0   = 3;
  localparam int BO1   = 5;
  localparam int BO2   = 7;
  localparam int COOL  = 4;
  localparam int RECOV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic admit = 1'b0, fault = 1'b0, ot = 1'b0, clr = 1'b0, tk = 1'b0;
  logic       pwr_en, log_vld;
  logic [1:0] lim_lvl, pol_state, retry_idx, log_dec;
  logic [2:0] log_src;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_policy_fsm #(
    .LIM_STEPS(STEPS), .RETRY_MAX(RMAX), .BACKOFF0_MS(BO0), .BACKOFF1_MS(BO1),
    .BACKOFF2_MS(BO2), .COOL_MS(COOL), .RECOVER_MS(RECOV)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .admit(admit), .fault(fault), .over_temp(ot),
    .clr_cmd(clr), .ms_tick(tk), .pwr_en(pwr_en), .lim_lvl(lim_lvl),
    .pol_state(pol_state), .retry_idx(retry_idx), .log_vld(log_vld),
    .log_src(log_src), .log_dec(log_dec)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    fault = 1'b0;
    clr = 1'b0;
    tk = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tk = 1'b1;
      step();
    end
  endtask

  task automatic chk_log(input string req, input int src, input int dec);
    chk(req, "log_vld", int'(log_vld), 1);
    chk(req, "log_src", int'(log_src), src);
    chk(req, "log_dec", int'(log_dec), dec);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) step();
    chk("R1", "state", int'(pol_state), 2);
    chk("R1", "enable", int'(pwr_en), 0);
    chk("R1", "level", int'(lim_lvl), 0);
    chk("R1", "retry", int'(retry_idx), 0);
    chk("R1", "log", int'(log_vld), 0);
    rst_n = 1'b1;
    step();
    chk("R2", "no admission stays deny", int'(pol_state), 2);

    admit = 1'b1; ot = 1'b1;
    step(); step();
    chk("R5", "hot blocks allow", int'(pol_state), 2);
    ot = 1'b0;
    step();
    chk("R2", "allow entry", int'(pol_state), 0);
    chk("R2", "enable", int'(pwr_en), 1);
    chk_log("R11", 1, 0);
    step();
    chk("R11", "strobe one cycle", int'(log_vld), 0);
    ticks(2 * RECOV);
    chk("R7", "ticks in allow", int'(pol_state), 0);
    chk("R7", "allow level", int'(lim_lvl), 0);

    for (int n = 1; n <= STEPS; n++) begin
      fault = 1'b1;
      step();
      chk(n == 1 ? "R3" : "R4", "state", int'(pol_state), 1);
      chk(n == 1 ? "R3" : "R4", "level", int'(lim_lvl), n);
      chk(n == 1 ? "R3" : "R4", "enable", int'(pwr_en), 1);
      chk_log("R11", 2, 1);
    end

    ticks(RECOV - 1);
    chk("R7", "no step early", int'(lim_lvl), STEPS);
    ticks(1);
    chk("R7", "step down", int'(lim_lvl), STEPS - 1);
    chk_log("R11", 4, 1);
    ticks(RECOV - 1);
    admit = 1'b0;
    step();
    chk("R6", "pg drop raises step", int'(lim_lvl), STEPS);
    chk_log("R6", 1, 1);
    step();
    chk("R6", "low level no event", int'(log_vld), 0);
    chk("R6", "low level step", int'(lim_lvl), STEPS);
    admit = 1'b1;
    ticks(RECOV - 1);
    chk("R7", "counter restarted", int'(lim_lvl), STEPS);
    for (int l = STEPS - 1; l >= 0; l--) begin
      ticks(l == STEPS - 1 ? 1 : RECOV);
      chk("R7", "recovery level", int'(lim_lvl), l);
    end
    chk("R7", "back to allow", int'(pol_state), 0);
    chk_log("R11", 4, 0);

    for (int n = 1; n <= STEPS + 1; n++) begin
      fault = 1'b1;
      step();
    end
    chk("R4", "fault at last step", int'(pol_state), 2);
    chk("R4", "enable off", int'(pwr_en), 0);
    chk("R8", "retry index", int'(retry_idx), 1);
    chk_log("R11", 2, 2);
    for (int i = 1; i <= BO0; i++) begin
      ticks(1);
      chk("R8", "backoff0 wait", int'(pol_state), 2);
    end
    step();
    chk("R8", "exit after backoff0", int'(pol_state), 0);
    clr = 1'b1;
    step();
    chk("R10", "clear in allow retry", int'(retry_idx), 1);
    chk("R10", "clear in allow log", int'(log_vld), 0);

    fault = 1'b1;
    step();
    chk("R3", "limit again", int'(pol_state), 1);
    fault = 1'b1; ot = 1'b1;
    step();
    chk("R5", "hot wins over fault", int'(pol_state), 2);
    chk_log("R5", 3, 2);
    chk("R8", "retry index 2", int'(retry_idx), 2);
    ot = 1'b0;
    ticks(BO1);
    chk("R8", "backoff1 still deny", int'(pol_state), 2);
    ot = 1'b1;
    step();
    chk("R5", "hot holds deny", int'(pol_state), 2);
    ot = 1'b0;
    step();
    chk("R8", "exit after backoff1", int'(pol_state), 0);

    ot = 1'b1;
    step();
    chk("R9", "deny on exhausted", int'(pol_state), 2);
    chk("R9", "retry stays", int'(retry_idx), RMAX);
    ot = 1'b0;
    clr = 1'b1;
    step();
    chk("R10", "clear before cool ignored", int'(log_vld), 0);
    chk("R10", "retry kept", int'(retry_idx), RMAX);
    ticks(COOL - 1);
    clr = 1'b1;
    step();
    chk("R10", "clear one tick early", int'(log_vld), 0);
    ticks(1);
    ticks(BO2 + 3);
    chk("R9", "latched after many ticks", int'(pol_state), 2);
    clr = 1'b1;
    step();
    chk_log("R10", 5, 2);
    chk("R10", "retry cleared", int'(retry_idx), 0);
    step();
    chk("R2", "allow after clear", int'(pol_state), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule